// File: doc/BRIEF.md
# Buffered Serial Transmitter with Empty and Complete Flags

This block is the send half of an asynchronous serial port. A byte written over the bus either starts a frame at once, if the line is idle, or waits in a one-byte holding register until the frame on the line finishes. Software can then queue the next byte while the current one is still being sent, which keeps the line streaming without gaps.

Two status flags track progress. The holding-empty flag shows that the holding register can take another byte without losing data. The done flag shows that the last frame has fully left the line and nothing is queued behind it. Each flag has its own interrupt enable. The done flag clears in one of two ways: a status read followed by a data write, or a direct clear strobe. Turning the transmitter on first sends one frame time of idle-high preamble. Frames have 8 data bits, no parity and one stop bit. A baud tick input from outside sets the bit rate.

Top module: `uart_txd_top`

## Requirements
- R1: After reset the line is high, the holding-empty flag is 1, the done flag is 0 and both interrupt outputs are 0.
- R2: When the enable input rises, the line stays high for 10 baud ticks before any frame. A byte written in that time is held (empty flag 0) and starts when the preamble ends.
- R3: A frame is a low start bit, then 8 data bits with the LSB first, then a high stop bit. The transmitter moves to the next bit on each baud tick.
- R4: A write while the line is idle starts a frame on the next cycle (line low) and leaves the empty flag at 1.
- R5: A write while a frame or the preamble is in progress stores the byte. The empty flag reads 0 on the next cycle. When the current frame ends, the held byte goes straight out with no idle gap, and the empty flag returns to 1.
- R6: A second write while a byte is already held replaces that byte, so only the newest byte is sent.
- R7: The done flag is set when a stop bit (or the preamble) ends with no byte held and no write in that cycle. The line then goes idle. If a byte follows back-to-back, the flag is not set.
- R8: A data write clears the done flag only if a status read has come before it with no data write in between. A data write without that earlier read leaves the flag as it was.
- R9: A pulse on the direct clear input clears the done flag on the next cycle, unless a set happens in the same cycle (a set wins).
- R10: Each interrupt output is high exactly while its flag and its enable are both 1.
- R11: Dropping the enable input returns the line to high on the next cycle, throws away any held byte (empty flag 1) and ignores data writes until the input rises again. When it rises again, a new preamble is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| tx_enable | input | 1 | Transmitter on |
| wr_data | input | 1 | Data register write strobe |
| wr_byte | input | 8 | Byte written with the strobe |
| rd_status | input | 1 | Status register read strobe |
| tc_clear | input | 1 | Direct clear of the done flag |
| ie_empty | input | 1 | Interrupt enable for holding-empty |
| ie_done | input | 1 | Interrupt enable for done |
| tx_line | output | 1 | Serial output, idles high |
| flag_empty | output | 1 | Holding register empty |
| flag_done | output | 1 | Transmission complete |
| irq_empty | output | 1 | Holding-empty interrupt request |
| irq_done | output | 1 | Done interrupt request |

## Verification
The bench drives writes in four patterns:
- A write during the preamble checks that a byte waits until the preamble has fully ended.
- A write into an idle line checks that a byte bypasses the holding register.
- A single write during a frame checks that two frames run back-to-back.
- Several writes during one frame check that the newest held byte replaces the older one.

The done-flag clears are tried with and without the earlier status read, which shows whether the armed tracking works. A mid-frame disable with a byte held checks that the byte is discarded and that the next enable starts a fresh preamble.

// File: rtl/uart_txd_pkg.sv
// Shared types for the buffered serial transmitter.
package uart_txd_pkg;
    // Serializer operating states
    typedef enum logic [1:0] {
        SER_OFF   = 2'd0,
        SER_PRE   = 2'd1,
        SER_IDLE  = 2'd2,
        SER_FRAME = 2'd3
    } ser_state_t;
endpackage

// File: rtl/txd_serializer.sv
// Serializer: sends the idle preamble after enable, then frames of
// start bit, data (LSB first) and stop bit, one bit per baud tick.
// Assumes load is raised only while idle or on the cycle a segment ends.
module txd_serializer
    import uart_txd_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 tick,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] load_byte,
    output logic                 is_idle,
    output logic                 seg_end,
    output logic                 line
);
    localparam int FRAME_BITS = DATA_BITS + 2;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

    ser_state_t               state;
    logic [CNT_W-1:0]         cnt;
    logic [FRAME_BITS-1:0]    shreg;

    // Segment end: last bit period of preamble or frame closes on a tick
    always_comb begin
        seg_end = enable && tick && (cnt == LAST) &&
                  (state == SER_PRE || state == SER_FRAME);
        is_idle = (state == SER_IDLE);
        line    = shreg[0];
    end

    // State, bit counter and shift register sequencing
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state <= SER_OFF;
            cnt   <= '0;
            shreg <= '1;
        end else if (load) begin
            state <= SER_FRAME;
            cnt   <= '0;
            shreg <= {1'b1, load_byte, 1'b0};
        end else begin
            case (state)
                SER_OFF: begin
                    state <= SER_PRE;
                    cnt   <= '0;
                end
                SER_PRE, SER_FRAME: begin
                    if (tick) begin
                        if (cnt == LAST) begin
                            state <= SER_IDLE;
                            cnt   <= '0;
                            shreg <= '1;
                        end else begin
                            cnt   <= cnt + 1'b1;
                            shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R3: a loaded frame opens with a low start bit
    a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (load && enable) |=> !line);
    // R2: line holds high across the preamble
    a_r2_preamble_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SER_PRE) |-> line);
    // R11: disabling returns the line high
    a_r11_off_high: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> line);
endmodule

// File: rtl/txd_hold.sv
// Holding register: takes bus writes, forwards a byte to the serializer
// when it can load, and bypasses itself when empty and the line is free.
// Assumes wr is already qualified by the transmitter enable.
module txd_hold #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 wr,
    input  logic [DATA_BITS-1:0] wr_byte,
    input  logic                 can_load,
    output logic                 empty,
    output logic                 load,
    output logic [DATA_BITS-1:0] load_byte
);
    logic                 full;
    logic [DATA_BITS-1:0] held;
    logic                 bypass;
    logic                 take;
    logic                 store;

    // Choose between the held byte and a direct write
    always_comb begin
        take      = can_load && full;
        bypass    = can_load && !full && wr;
        store     = wr && !bypass;
        load      = take || bypass;
        load_byte = full ? held : wr_byte;
        empty     = !full;
    end

    // Holding register occupancy and content
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            full <= 1'b0;
            held <= '0;
        end else if (store) begin
            full <= 1'b1;
            held <= wr_byte;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // R5: a write that cannot go straight out clears the empty flag
    a_r5_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && wr && !(can_load && !full)) |=> !empty);
    // R4: a bypassing write keeps the empty flag set
    a_r4_bypass_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && wr && can_load && !full) |=> empty);
endmodule

// File: rtl/txd_done.sv
// Done flag with armed tracking: a status read arms, a following data
// write clears the flag; a direct clear also works; a set wins.
module txd_done (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr_zero,
    input  logic rd,
    input  logic wr_acc,
    output logic done
);
    logic armed;

    // Arm on status read, disarm on accepted data write
    always_ff @(posedge clk) begin
        if (!rst_n)      armed <= 1'b0;
        else if (rd)     armed <= 1'b1;
        else if (wr_acc) armed <= 1'b0;
    end

    // Done flag set and clear priorities
    always_ff @(posedge clk) begin
        if (!rst_n)                 done <= 1'b0;
        else if (set)               done <= 1'b1;
        else if (clr_zero)          done <= 1'b0;
        else if (wr_acc && armed)   done <= 1'b0;
    end

    // R7: a set shows on the next cycle
    a_r7_set_seen: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> done);
    // R8: a write without an earlier read leaves the flag alone
    a_r8_unarmed_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && !armed && !set && !clr_zero) |=> (done == $past(done)));
    // R9: direct clear takes effect unless a set coincides
    a_r9_direct_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_zero && !set) |=> !done);
endmodule

// File: rtl/uart_txd_top.sv
// Buffered serial transmitter top: ties the holding register, the
// serializer and the done flag together and forms the interrupt requests.
// Assumes baud_tick is a single-cycle pulse once per bit period.
module uart_txd_top #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 baud_tick,
    input  logic                 tx_enable,
    input  logic                 wr_data,
    input  logic [DATA_BITS-1:0] wr_byte,
    input  logic                 rd_status,
    input  logic                 tc_clear,
    input  logic                 ie_empty,
    input  logic                 ie_done,
    output logic                 tx_line,
    output logic                 flag_empty,
    output logic                 flag_done,
    output logic                 irq_empty,
    output logic                 irq_done
);
    logic                 wr_acc;
    logic                 can_load;
    logic                 load;
    logic [DATA_BITS-1:0] load_byte;
    logic                 ser_idle;
    logic                 ser_end;
    logic                 set_done;

    // Glue: write qualification, load window, done-flag set, interrupts
    always_comb begin
        wr_acc    = wr_data && tx_enable;
        can_load  = ser_idle || ser_end;
        set_done  = ser_end && !load;
        irq_empty = flag_empty && ie_empty;
        irq_done  = flag_done && ie_done;
    end

    txd_hold #(.DATA_BITS(DATA_BITS)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (tx_enable),
        .wr       (wr_acc),
        .wr_byte  (wr_byte),
        .can_load (can_load),
        .empty    (flag_empty),
        .load     (load),
        .load_byte(load_byte)
    );

    txd_serializer #(.DATA_BITS(DATA_BITS)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (tx_enable),
        .tick     (baud_tick),
        .load     (load),
        .load_byte(load_byte),
        .is_idle  (ser_idle),
        .seg_end  (ser_end),
        .line     (tx_line)
    );

    txd_done u_done (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (set_done),
        .clr_zero(tc_clear),
        .rd      (rd_status),
        .wr_acc  (wr_acc),
        .done    (flag_done)
    );

    // R7: done rises only where a segment ended
    a_r7_rise_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_done) |-> $past(ser_end));
    // R5: empty flag rises only on a transfer or a disable
    a_r5_empty_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_empty) |-> $past((can_load && !flag_empty) || !tx_enable));
    // R11: writes while disabled leave the holding register empty
    a_r11_ignore_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_enable && wr_data) |=> flag_empty);
endmodule

// File: tb/uart_txd_top_test.sv
module uart_txd_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       tx_enable = 1'b0;
    logic       wr_data = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       rd_status = 1'b0;
    logic       tc_clear = 1'b0;
    logic       ie_empty = 1'b0;
    logic       ie_done = 1'b0;
    logic       tx_line, flag_empty, flag_done, irq_empty, irq_done;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    started = 1'b0;

    // reference model state
    int         m_mode = 0;   // 0 off, 1 preamble, 2 idle, 3 frame
    int         m_cnt = 0;
    logic [9:0] m_fr = '1;
    logic [7:0] m_q[$];
    bit         m_tc = 1'b0;
    bit         m_armed = 1'b0;
    bit         m_wacc, m_old, m_set, m_endf;
    int         tdiv = 0;

    always #4 clk = ~clk;   // 125 MHz

    uart_txd_top uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_enable(tx_enable),
        .wr_data(wr_data), .wr_byte(wr_byte), .rd_status(rd_status),
        .tc_clear(tc_clear), .ie_empty(ie_empty), .ie_done(ie_done),
        .tx_line(tx_line), .flag_empty(flag_empty), .flag_done(flag_done),
        .irq_empty(irq_empty), .irq_done(irq_done)
    );

    // baud tick every fourth clock
    initial forever begin
        @(posedge clk); #2;
        baud_tick = (tdiv == 3);
        tdiv = (tdiv + 1) % 4;
    end

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_fr = '1; m_q.delete(); m_tc = 0; m_armed = 0;
        end else begin
            m_wacc = wr_data && tx_enable;
            m_old  = m_armed;
            m_set  = 0;
            if (rd_status) m_armed = 1;
            else if (m_wacc) m_armed = 0;
            if (!tx_enable) begin
                m_mode = 0; m_cnt = 0; m_q.delete();
            end else begin
                m_endf = baud_tick && (m_mode == 1 || m_mode == 3) && m_cnt == 9;
                if (m_mode == 0) begin
                    m_mode = 1; m_cnt = 0;
                    if (m_wacc) begin m_q.delete(); m_q.push_back(wr_byte); end
                end else if (m_mode == 2 || m_endf) begin
                    if (m_q.size() > 0) begin
                        m_fr = {1'b1, m_q.pop_front(), 1'b0}; m_mode = 3; m_cnt = 0;
                        if (m_wacc) m_q.push_back(wr_byte);
                    end else if (m_wacc) begin
                        m_fr = {1'b1, wr_byte, 1'b0}; m_mode = 3; m_cnt = 0;
                    end else begin
                        if (m_endf) m_set = 1;
                        m_mode = 2; m_cnt = 0;
                    end
                end else begin
                    if (baud_tick) m_cnt++;
                    if (m_wacc) begin m_q.delete(); m_q.push_back(wr_byte); end
                end
            end
            if (m_set) m_tc = 1;
            else if (tc_clear) m_tc = 0;
            else if (m_wacc && m_old) m_tc = 0;
            started = 1'b1;
        end
    end

    task automatic cmp(string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %b expected %b at %0t", cur_req, what, got, exp, $time);
        end
    endtask

    // compare every clock, away from the rising edge
    always @(negedge clk) begin
        if (started) begin
            logic e_line, e_empty;
            e_line  = (m_mode == 3) ? m_fr[m_cnt] : 1'b1;
            e_empty = (m_q.size() == 0);
            cmp("tx_line", tx_line, e_line);
            cmp("flag_empty", flag_empty, e_empty);
            cmp("flag_done", flag_done, m_tc);
            cmp("irq_empty", irq_empty, e_empty && ie_empty);
            cmp("irq_done", irq_done, m_tc && ie_done);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic put(logic [7:0] b);
        @(posedge clk); #2; wr_data = 1; wr_byte = b;
        @(posedge clk); #2; wr_data = 0;
    endtask

    task automatic rd_pulse();
        @(posedge clk); #2; rd_status = 1;
        @(posedge clk); #2; rd_status = 0;
    endtask

    task automatic clr_pulse();
        @(posedge clk); #2; tc_clear = 1;
        @(posedge clk); #2; tc_clear = 0;
    endtask

    task automatic set_en(logic v);
        @(posedge clk); #2; tx_enable = v;
    endtask

    // watchdog
    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cur_req = "R1";
        cyc(3); #2 rst_n = 1;
        cyc(5);
        // R1 explicit reset-state check
        @(negedge clk);
        cmp("R1 reset line", tx_line, 1'b1);
        cmp("R1 reset empty", flag_empty, 1'b1);
        cmp("R1 reset done", flag_done, 1'b0);

        cur_req = "R2"; set_en(1); cyc(10); put(8'hA5); cyc(35);
        cur_req = "R3"; cyc(50);
        cur_req = "R7"; cyc(5);
        cur_req = "R8"; put(8'h3C); cyc(50);
        rd_pulse(); put(8'h81); cyc(50);
        cur_req = "R4"; put(8'h55); cyc(3);
        cur_req = "R5"; put(8'h0F); cyc(90);
        cur_req = "R6"; put(8'h11); cyc(5); put(8'h22); put(8'h33); cyc(130);
        cur_req = "R9"; clr_pulse(); cyc(5);
        cur_req = "R10"; @(posedge clk); #2 ie_empty = 1; ie_done = 1;
        cyc(3); put(8'h99); cyc(60); rd_pulse(); put(8'h66); cyc(50);
        @(posedge clk); #2 ie_empty = 0; ie_done = 0; cyc(3);
        cur_req = "R11"; put(8'hF0); cyc(15); put(8'h44); cyc(3);
        set_en(0); cyc(5); put(8'h77); cyc(5); set_en(1); cyc(100);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule